// File: doc/BRIEF.md
# Hash Offload Control Register File

This block is the software-facing control point of a hash offload engine. A 32-bit register bus writes the job parameters (source pointer, digest pointer, key buffer pointer, byte length and a global mode word) into masked registers, then writes the hash command word. That command write launches a job on the downstream engine: a one-cycle start pulse goes out together with a snapshot of the command and pointer values.

While a job runs, the hash busy flag is set. The engine's done pulse clears busy, sets the hash interrupt flag and drives the interrupt line. Software clears the flag by writing a one to it. Bits that a configuration does not implement are dropped on write. The digest pointer is always 8-byte aligned. The symmetric-crypto and RSA status bits are reserved placeholders and always read zero.

Top module: `hash_ctl_regs`

## Requirements
- R1: After reset every register reads 0, including the status word, and `job_start` and `irq_hash` are low.
- R2: The source pointer (offset 0x20) and key pointer (offset 0x28) keep only bits [SRC_BITS-1:0]. With the default of 31, writing 0xFFFFFFFF reads back 0x7FFFFFFF.
- R3: The digest pointer (offset 0x24) uses the source mask with bits [2:0] forced to zero. With the default, writing 0xFFFFFFFF reads back 0x7FFFFFF8, and `job_dst[2:0]` is always zero.
- R4: The length register (offset 0x2C) keeps only bits [LEN_BITS-1:0]. With the default of 28, writing 0xFFFFFFFF reads back 0x0FFFFFFF.
- R5: A write to the hash command (offset 0x30) while idle does three things. It stores the command masked to 0x0004057C (algorithm bits 4, 5, 6 and 10; SHA byte-order bit 3; MD5 byte-order bit 2; accumulate bit 8; scatter-gather bit 18). In the following cycle it raises `job_start` for exactly one cycle, with `job_cmd`, `job_src`, `job_dst` and `job_len` equal to the stored values. It also sets status bit 0 (hash busy), so status reads 0x00000001.
- R6: A `job_done` pulse while busy clears bit 0 and sets bit 9, so status reads exactly 0x00000200 and `irq_hash` is high. A `job_done` pulse while idle has no effect.
- R7: The status register (offset 0x1C) is write-one-to-clear on bits 9, 12 and 13. Writing 0x00000200 returns it to 0. Writing any value with bit 9 at zero leaves bit 9 unchanged.
- R8: A hash command write while busy is ignored: no `job_start` pulse follows, and the command register keeps its previous value.
- R9: A read request is answered in the next cycle with `bus_rvalid` high for one cycle. Unmapped offsets read 0. Writes produce no `bus_rvalid`.
- R10: Status bits 1, 2, 12 and 13 (crypto and RSA busy and interrupt) always read 0.
- R11: The global mode register (offset 0x10) stores all 32 bits, and writing it starts no job.
- R12: If `job_done` and a status write that clears bit 9 arrive in the same cycle, the interrupt flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| bus_rdata | output | 32 | Read data |
| job_start | output | 1 | One-cycle job launch pulse |
| job_cmd | output | 32 | Command snapshot for the job |
| job_src | output | 32 | Source pointer snapshot |
| job_dst | output | 32 | Digest pointer snapshot |
| job_len | output | 32 | Length snapshot |
| job_done | input | 1 | Engine completion pulse |
| irq_hash | output | 1 | Hash interrupt flag |

## Verification
The assertions check the following on every cycle. Each launch pulse lasts one cycle and is accompanied by busy. No launch follows a command write made while busy. A completion pulse taken while busy sets the interrupt flag and clears busy. The flag holds until a one is written to bit 9. The placeholder bits stay zero, the digest snapshot stays aligned, and every read is answered one cycle later.

Only the directed scenarios show the other behaviours: the exact masked read-back values, the bit encoding of the stored command, the snapshot contents of a job, the ignored command value, and the outcome when a clear and a completion collide.

// File: rtl/hctl_pkg.sv
package hctl_pkg;
  localparam int NUM_SEL = 7;
  localparam int SEL_MODE = 0;
  localparam int SEL_STAT = 1;
  localparam int SEL_SRC  = 2;
  localparam int SEL_DST  = 3;
  localparam int SEL_KEY  = 4;
  localparam int SEL_LEN  = 5;
  localparam int SEL_CMD  = 6;

  localparam logic [7:0] OFS_MODE = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h1C;
  localparam logic [7:0] OFS_SRC  = 8'h20;
  localparam logic [7:0] OFS_DST  = 8'h24;
  localparam logic [7:0] OFS_KEY  = 8'h28;
  localparam logic [7:0] OFS_LEN  = 8'h2C;
  localparam logic [7:0] OFS_CMD  = 8'h30;

  localparam int ST_HASH_BUSY = 0;
  localparam int ST_HASH_IRQ  = 9;
  localparam int ST_CRY_IRQ   = 12;
  localparam int ST_RSA_IRQ   = 13;

  localparam logic [31:0] CMD_MASK = 32'h0004_057C;

  function automatic logic [31:0] low_mask(input int bits);
    logic [63:0] m;
    m = (64'd1 << bits) - 64'd1;
    return m[31:0];
  endfunction

  function automatic logic [31:0] align8_mask(input int bits);
    return low_mask(bits) & ~32'h7;
  endfunction

  function automatic logic [7:0] sel_offset(input int sel);
    case (sel)
      SEL_MODE: return OFS_MODE;
      SEL_STAT: return OFS_STAT;
      SEL_SRC:  return OFS_SRC;
      SEL_DST:  return OFS_DST;
      SEL_KEY:  return OFS_KEY;
      SEL_LEN:  return OFS_LEN;
      default:  return OFS_CMD;
    endcase
  endfunction
endpackage

// File: rtl/hctl_decode.sv
module hctl_decode
  import hctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_SEL-1:0] hit,
  output logic [NUM_SEL-1:0] wr_sel,
  output logic               rd_req
);
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign hit[g]    = (bus_addr == ADDR_W'(sel_offset(g)));
    assign wr_sel[g] = bus_valid && bus_write && hit[g];
  end
  assign rd_req = bus_valid && !bus_write;
endmodule

// File: rtl/hctl_mreg.sv
module hctl_mreg #(
  parameter logic [31:0] MASK = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & MASK;
  end
endmodule

// File: rtl/hctl_status.sv
module hctl_status
  import hctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic        stat_wr,
  input  logic [31:0] wdata,
  input  logic        job_done,
  output logic        accept,
  output logic        busy,
  output logic        irq,
  output logic [31:0] status_word
);
  logic clr_irq;
  assign accept  = cmd_wr && !busy;
  assign clr_irq = stat_wr && wdata[ST_HASH_IRQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (accept)              busy <= 1'b1;
      else if (job_done)       busy <= 1'b0;
      if (job_done && busy)    irq  <= 1'b1;
      else if (clr_irq)        irq  <= 1'b0;
    end
  end

  always_comb begin
    status_word = '0;
    status_word[ST_HASH_BUSY] = busy;
    status_word[ST_HASH_IRQ]  = irq;
  end
endmodule

// File: rtl/hash_ctl_regs.sv
module hash_ctl_regs
  import hctl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SRC_BITS = 31,
  parameter int LEN_BITS = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic              job_start,
  output logic [31:0]       job_cmd,
  output logic [31:0]       job_src,
  output logic [31:0]       job_dst,
  output logic [31:0]       job_len,
  input  logic              job_done,
  output logic              irq_hash
);
  localparam logic [31:0] SRC_MASK = low_mask(SRC_BITS);
  localparam logic [31:0] DST_MASK = align8_mask(SRC_BITS);
  localparam logic [31:0] LEN_MASK = low_mask(LEN_BITS);

  logic [NUM_SEL-1:0] hit, wr_sel;
  logic rd_req;
  logic [31:0] mode_q, src_q, dst_q, key_q, len_q, cmd_q, status_word;
  logic accept, busy_w, irq_w;
  logic cmd_wr_evt, stat_wr_evt;

  hctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .hit(hit), .wr_sel(wr_sel), .rd_req(rd_req)
  );

  assign cmd_wr_evt  = wr_sel[SEL_CMD];
  assign stat_wr_evt = wr_sel[SEL_STAT];

  hctl_mreg #(.MASK(32'hFFFF_FFFF)) u_mode (
    .clk(clk), .rst_n(rst_n), .we(wr_sel[SEL_MODE]), .wdata(bus_wdata), .q(mode_q));
  hctl_mreg #(.MASK(SRC_MASK)) u_src (
    .clk(clk), .rst_n(rst_n), .we(wr_sel[SEL_SRC]), .wdata(bus_wdata), .q(src_q));
  hctl_mreg #(.MASK(DST_MASK)) u_dst (
    .clk(clk), .rst_n(rst_n), .we(wr_sel[SEL_DST]), .wdata(bus_wdata), .q(dst_q));
  hctl_mreg #(.MASK(SRC_MASK)) u_key (
    .clk(clk), .rst_n(rst_n), .we(wr_sel[SEL_KEY]), .wdata(bus_wdata), .q(key_q));
  hctl_mreg #(.MASK(LEN_MASK)) u_len (
    .clk(clk), .rst_n(rst_n), .we(wr_sel[SEL_LEN]), .wdata(bus_wdata), .q(len_q));

  hctl_status u_stat (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr_evt), .stat_wr(stat_wr_evt),
    .wdata(bus_wdata), .job_done(job_done), .accept(accept),
    .busy(busy_w), .irq(irq_w), .status_word(status_word)
  );
  assign irq_hash = irq_w;

  // Command register and job snapshot: updated only by an accepted command.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      job_start <= 1'b0;
      job_cmd   <= '0;
      job_src   <= '0;
      job_dst   <= '0;
      job_len   <= '0;
    end else begin
      job_start <= accept;
      if (accept) begin
        cmd_q   <= bus_wdata & CMD_MASK;
        job_cmd <= bus_wdata & CMD_MASK;
        job_src <= src_q;
        job_dst <= dst_q;
        job_len <= len_q;
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit[SEL_MODE]: rd_mux = mode_q;
      hit[SEL_STAT]: rd_mux = status_word;
      hit[SEL_SRC]:  rd_mux = src_q;
      hit[SEL_DST]:  rd_mux = dst_q;
      hit[SEL_KEY]:  rd_mux = key_q;
      hit[SEL_LEN]:  rd_mux = len_q;
      hit[SEL_CMD]:  rd_mux = cmd_q;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/hash_ctl_regs_chk.sv
module hash_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic        cmd_wr_evt,
  input logic        stat_wr_evt,
  input logic [31:0] bus_wdata,
  input logic        busy,
  input logic        irq,
  input logic [31:0] status_word,
  input logic        job_start,
  input logic        job_done,
  input logic [31:0] job_dst,
  input logic        bus_rvalid
);
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |=> !job_start);
  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |-> busy);
  p_done_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (job_done && busy) |=> (irq && !busy));
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(stat_wr_evt && bus_wdata[9])) |=> irq);
  p_ignore_busy_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_evt && busy) |=> !job_start);
  p_read_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  p_no_spurious_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);
  p_placeholders_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[13:12] == 2'b00) && (status_word[2:1] == 2'b00));
  p_dst_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    job_dst[2:0] == 3'b000);
endmodule

bind hash_ctl_regs hash_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .cmd_wr_evt(cmd_wr_evt),
  .stat_wr_evt(stat_wr_evt), .bus_wdata(bus_wdata), .busy(busy_w), .irq(irq_w),
  .status_word(status_word), .job_start(job_start), .job_done(job_done),
  .job_dst(job_dst), .bus_rvalid(bus_rvalid)
);

// File: tb/hash_ctl_regs_bench.sv
`timescale 1ns/1ps
module hash_ctl_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  logic job_start, job_done = 1'b0, irq_hash;
  logic [31:0] job_cmd, job_src, job_dst, job_len;
  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hash_ctl_regs u_hash_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .job_start(job_start), .job_cmd(job_cmd),
    .job_src(job_src), .job_dst(job_dst), .job_len(job_len),
    .job_done(job_done), .irq_hash(irq_hash)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    chk("R9 no rvalid on write", {31'd0, bus_rvalid}, 32'd0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R9 rvalid", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk); job_done = 1'b1;
    @(negedge clk); job_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 start low", {31'd0, job_start}, 32'd0);
    chk("R1 irq low", {31'd0, irq_hash}, 32'd0);
    for (int i = 0; i < 7; i++) begin
      logic [7:0] ofs [7] = '{8'h10, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30};
      rd_chk("R1 reset value", ofs[i], 32'd0);
    end
  endtask

  task automatic t_masks();
    wr(8'h20, 32'hFFFF_FFFF); rd_chk("R2 src mask", 8'h20, 32'h7FFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF); rd_chk("R2 key mask", 8'h28, 32'h7FFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF); rd_chk("R3 dst mask", 8'h24, 32'h7FFF_FFF8);
    wr(8'h24, 32'h0000_1237); rd_chk("R3 dst align", 8'h24, 32'h0000_1230);
    wr(8'h2C, 32'hFFFF_FFFF); rd_chk("R4 len mask", 8'h2C, 32'h0FFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    chk("R11 mode no start", {31'd0, job_start}, 32'd0);
    rd_chk("R11 mode full", 8'h10, 32'hFFFF_FFFF);
    rd_chk("R11 status idle", 8'h1C, 32'd0);
    rd_chk("R9 unmapped", 8'h04, 32'd0);
  endtask

  task automatic t_job(input logic [31:0] cmd, input logic [31:0] src,
                       input logic [31:0] dst, input logic [31:0] len);
    wr(8'h20, src); wr(8'h24, dst); wr(8'h2C, len);
    wr(8'h30, cmd);
    chk("R5 start pulse", {31'd0, job_start}, 32'd1);
    chk("R5 job cmd", job_cmd, cmd & 32'h0004_057C);
    chk("R5 job src", job_src, src & 32'h7FFF_FFFF);
    chk("R5 job dst", job_dst, dst & 32'h7FFF_FFF8);
    chk("R5 job len", job_len, len & 32'h0FFF_FFFF);
    @(negedge clk);
    chk("R5 start one cycle", {31'd0, job_start}, 32'd0);
    rd_chk("R5 busy", 8'h1C, 32'h0000_0001);
    rd_chk("R5 cmd readback", 8'h30, cmd & 32'h0004_057C);
    wr(8'h30, 32'h0000_0020);
    chk("R8 no start when busy", {31'd0, job_start}, 32'd0);
    rd_chk("R8 cmd unchanged", 8'h30, cmd & 32'h0004_057C);
    pulse_done();
    rd_chk("R6 status done", 8'h1C, 32'h0000_0200);
    chk("R6 irq line", {31'd0, irq_hash}, 32'd1);
    wr(8'h1C, 32'hFFFF_FDFF);
    rd_chk("R7 other bits no effect", 8'h1C, 32'h0000_0200);
    wr(8'h1C, 32'h0000_0200);
    rd_chk("R7 cleared", 8'h1C, 32'd0);
    chk("R7 irq line low", {31'd0, irq_hash}, 32'd0);
  endtask

  task automatic t_idle_done();
    pulse_done();
    rd_chk("R6 done while idle", 8'h1C, 32'd0);
    chk("R10 placeholders", {31'd0, irq_hash}, 32'd0);
  endtask

  task automatic t_collide();
    wr(8'h30, 32'h0000_0058);
    pulse_done();
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h0000_3200;
    job_done = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; job_done = 1'b0;
    rd_chk("R12 irq cleared by write", 8'h1C, 32'd0);
    wr(8'h30, 32'h0000_0058);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h0000_3200;
    job_done = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; job_done = 1'b0;
    rd_chk("R12 set wins", 8'h1C, 32'h0000_0200);
    wr(8'h1C, 32'h0000_3200);
    rd_chk("R10 status clean", 8'h1C, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masks();
    t_job(32'h0000_0058, 32'h0000_1000, 32'h0000_2004, 32'd3);
    t_job(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_idle_done();
    t_collide();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule